// File: doc/BRIEF.md
# Bit-Addressable GPIO Port Bank

This block holds four 8-bit bidirectional I/O ports, called A, B, C and F. Each port has an output latch and a direction register. A CPU reaches both through a small register bus. Each write is a single cycle. A bit operation works as a read-modify-write: it takes the levels currently present on the whole port, changes one bit, and writes the full byte back into the latch. Because of this, input-mode pins copy their outside level into the latch.

Port C implements only its lower six bits and port F only bit 0. The missing bits read as zero, ignore writes and never drive. Port A watches its lines while the device sleeps and raises a wake level when any of them moves.

Port B bit 0 shares its pad with a frequency-divider signal. A build option selects this sharing. When it is selected, the latch bit gates the divider signal onto the pad. Port F bit 0 and port C bit 0 are passed straight out as the interrupt input and the timer clock input.

Top module: `gpio_bank`

## Requirements
- R1: After reset every direction bit is 1 (input), so no pad drives. Each output latch resets to all implemented bits 1 when that port's pull-up option bit is set, and to 0 otherwise.
- R2: Address 2k selects the latch of port k and 2k+1 its direction register, with A=0, B=1, C=2, F=3. A write loads the addressed register at the next clock edge. A direction bit of 0 makes that pad an output.
- R3: Reading a latch address returns the live pad levels of that port. Reading a direction address returns the direction register. Reads are combinational.
- R4: `bop_kind` selects the bit operation: 1 sets, 2 clears, 3 complements, 0 does nothing. The operation reads the addressed register's current value, which for a latch address is the port's pad levels. It modifies bit `bop_bit` and stores the whole byte. A write in the same cycle takes precedence.
- R5: Port C bits 7:6 and port F bits 7:1 read 0, ignore writes and bit operations, and never drive their pads.
- R6: While `sleep_en` is 1, any change on a port A pad sets `wake` one clock edge later. `wake` then stays 1 while `sleep_en` stays 1.
- R7: `wake` is 0 one edge after `sleep_en` is 0, and port A changes while `sleep_en` is 0 never set it.
- R8: When port B direction bit 0 is 1, pad B0 does not drive, whatever the frequency option.
- R9: With the frequency option off and B0 in output mode, pad B0 drives latch B bit 0.
- R10: With the frequency option on and B0 in output mode, pad B0 drives 0 when latch B bit 0 is 0, and drives `freq_in` when it is 1.
- R11: `ext_int` follows pad F0 and `tmr_clk` follows pad C0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register select: port index in bits 2:1, direction register when bit 0 is 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bop_kind | input | 2 | Bit operation: 0 none, 1 set, 2 clear, 3 complement |
| bop_bit | input | 3 | Bit index for the bit operation |
| bus_rdata | output | 8 | Read data for the addressed register |
| pad_in | input | 32 | Pad levels, port k in bits 8k+7:8k |
| pad_out | output | 32 | Pad output values, same layout |
| pad_oe | output | 32 | Pad drive enables, same layout |
| freq_in | input | 1 | Frequency-divider signal for pad B0 |
| sleep_en | input | 1 | Device asleep |
| wake | output | 1 | Port A wake request level |
| ext_int | output | 1 | Interrupt input taken from pad F0 |
| tmr_clk | output | 1 | Timer clock input taken from pad C0 |

## Verification
The hardest case to reach is a bit operation on a port whose pins mix output and input directions while the outside world holds levels that differ from the latch. Only then does reading the pads instead of the latch change the outcome. The bench models the pads as a loop-back of driven bits merged with bench-held levels on undriven bits. It splits port B into an output nibble and an input nibble, changes the input nibble between operations, and checks that the stored byte picks up the outside levels. A second instance, built with the frequency option and pull-ups off, receives the same bus traffic, so the two pad B0 behaviours and the two reset latch values are compared on identical sequences.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int         W        = 8,
  parameter logic [3:0] PULLUP   = 4'hF,
  parameter bit         FREQ_OPT = 1'b1,
  parameter int         C_IMPL   = 6,
  parameter int         F_IMPL   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [W-1:0]       bus_wdata,
  input  logic [1:0]         bop_kind,
  input  logic [$clog2(W)-1:0] bop_bit,
  output logic [W-1:0]       bus_rdata,
  input  logic [4*W-1:0]     pad_in,
  output logic [4*W-1:0]     pad_out,
  output logic [4*W-1:0]     pad_oe,
  input  logic               freq_in,
  input  logic               sleep_en,
  output logic               wake,
  output logic               ext_int,
  output logic               tmr_clk
);
  localparam int NP = 4;
  localparam logic [W-1:0] FULL = {W{1'b1}};
  localparam logic [W-1:0] C_MSK = FULL >> (W - C_IMPL);
  localparam logic [W-1:0] F_MSK = FULL >> (W - F_IMPL);
  localparam logic [W-1:0] MSK [NP] = '{FULL, FULL, C_MSK, F_MSK};

  logic [W-1:0] lat   [NP];
  logic [W-1:0] ctl   [NP];
  logic [W-1:0] pin_v [NP];
  logic [W-1:0] prev_a;
  logic [4*W-1:0] impl_m;
  logic [W-1:0] hot;
  logic bop_go, b0_drv;

  assign hot    = {{(W-1){1'b0}}, 1'b1} << bop_bit;
  assign bop_go = !bus_wr && (bop_kind != 2'd0);

  function automatic logic [W-1:0] apply_op(input logic [W-1:0] v,
                                            input logic [1:0] k,
                                            input logic [W-1:0] h);
    case (k)
      2'd1:    apply_op = v | h;
      2'd2:    apply_op = v & ~h;
      2'd3:    apply_op = v ^ h;
      default: apply_op = v;
    endcase
  endfunction

  generate
    if (FREQ_OPT) begin : g_freq
      assign b0_drv = lat[1][0] & freq_in;
    end else begin : g_plain
      assign b0_drv = lat[1][0];
    end
  endgenerate

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic sel_d, sel_c;
    assign sel_d    = (bus_addr == 3'(2*p));
    assign sel_c    = (bus_addr == 3'(2*p+1));
    assign pin_v[p] = pad_in[p*W +: W] & MSK[p];
    assign impl_m[p*W +: W] = MSK[p];
    assign pad_oe[p*W +: W] = ~ctl[p] & MSK[p];

    if (p == 1) begin : g_shared
      assign pad_out[p*W +: W] = {lat[p][W-1:1], b0_drv};
    end else begin : g_normal
      assign pad_out[p*W +: W] = lat[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat[p] <= PULLUP[p] ? MSK[p] : '0;
        ctl[p] <= MSK[p];
      end else begin
        if (bus_wr && sel_d)      lat[p] <= bus_wdata & MSK[p];
        else if (bop_go && sel_d) lat[p] <= apply_op(pin_v[p], bop_kind, hot) & MSK[p];
        if (bus_wr && sel_c)      ctl[p] <= bus_wdata & MSK[p];
        else if (bop_go && sel_c) ctl[p] <= apply_op(ctl[p], bop_kind, hot) & MSK[p];
      end
    end
  end

  assign bus_rdata = bus_addr[0] ? ctl[bus_addr[2:1]] : pin_v[bus_addr[2:1]];
  assign ext_int   = pin_v[3][0];
  assign tmr_clk   = pin_v[2][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a <= '0;
      wake   <= 1'b0;
    end else begin
      prev_a <= pin_v[0];
      wake   <= sleep_en & (wake | (pin_v[0] != prev_a));
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int W        = 8,
  parameter bit FREQ_OPT = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         bus_addr,
  input logic               bus_wr,
  input logic [1:0]         bop_kind,
  input logic [$clog2(W)-1:0] bop_bit,
  input logic [W-1:0]       bus_rdata,
  input logic [4*W-1:0]     pad_in,
  input logic [4*W-1:0]     pad_out,
  input logic [4*W-1:0]     pad_oe,
  input logic [4*W-1:0]     impl_m,
  input logic               freq_in,
  input logic               sleep_en,
  input logic               wake,
  input logic [W-1:0]       lat_a,
  input logic               ctl_b0,
  input logic [W-1:0]       prev_a
);
  // R5
  unimpl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~impl_m) == '0);
  // R5
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[2:1] == 2'd3) |-> (bus_rdata[W-1:1] == '0));
  // R7
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_en |=> !wake);
  // R6
  wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_en && (pad_in[W-1:0] != prev_a)) |=> wake);
  // R8
  shared_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_b0 |-> !pad_oe[W]);
  // R10
  freq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (FREQ_OPT && pad_oe[W] && !freq_in) |-> !pad_out[W]);
  // R4
  bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && bop_kind == 2'd1 && bus_addr == 3'd0) |=> lat_a[$past(bop_bit)]);
endmodule

bind gpio_bank gpio_bank_chk #(.W(W), .FREQ_OPT(FREQ_OPT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bop_kind(bop_kind), .bop_bit(bop_bit), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .impl_m(impl_m),
  .freq_in(freq_in), .sleep_en(sleep_en), .wake(wake),
  .lat_a(lat[0]), .ctl_b0(ctl[1][0]), .prev_a(prev_a)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [1:0]  bop_kind = '0;
  logic [2:0]  bop_bit = '0;
  logic        freq_in = 1'b0, sleep_en = 1'b0;
  logic [31:0] ext = '0;

  logic [7:0]  rdata, rdata_nf;
  logic [31:0] pin, pout, poe, pin_nf, pout_nf, poe_nf;
  logic        wake, ext_int, tmr_clk, wake_nf, int_nf, tmr_nf;

  assign pin    = (poe & pout) | (~poe & ext);
  assign pin_nf = (poe_nf & pout_nf) | (~poe_nf & ext);

  gpio_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bop_kind(bop_kind), .bop_bit(bop_bit),
    .bus_rdata(rdata), .pad_in(pin), .pad_out(pout), .pad_oe(poe),
    .freq_in(freq_in), .sleep_en(sleep_en), .wake(wake),
    .ext_int(ext_int), .tmr_clk(tmr_clk));

  gpio_bank #(.PULLUP(4'h0), .FREQ_OPT(1'b0)) dut_nf (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bop_kind(bop_kind), .bop_bit(bop_bit),
    .bus_rdata(rdata_nf), .pad_in(pin_nf), .pad_out(pout_nf), .pad_oe(poe_nf),
    .freq_in(freq_in), .sleep_en(sleep_en), .wake(wake_nf),
    .ext_int(int_nf), .tmr_clk(tmr_nf));

  typedef struct {
    int          kind;
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  function automatic logic [31:0] observe(int k);
    case (k)
      0: return {24'd0, rdata};
      1: return pout;
      2: return poe;
      3: return {31'd0, wake};
      4: return {31'd0, ext_int};
      5: return {31'd0, tmr_clk};
      6: return pout_nf;
      7: return poe_nf;
      default: return {24'd0, rdata_nf};
    endcase
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it  = q.pop_front();
      got = observe(it.kind) & it.mask;
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic expect_v(int k, logic [31:0] m, logic [31:0] e, string t);
    item_t it;
    it.kind = k; it.mask = m; it.exp = e; it.tag = t;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bop(logic [2:0] a, logic [1:0] k, logic [2:0] b);
    bus_addr = a; bop_kind = k; bop_bit = b;
    @(posedge clk); #1;
    bop_kind = 2'd0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string t);
    bus_addr = a;
    expect_v(0, 32'hFF, {24'd0, e}, t);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;

    expect_v(2, 32'hFFFF_FFFF, 32'h0, "R1 no drive after reset");
    expect_v(7, 32'hFFFF_FFFF, 32'h0, "R1 no drive after reset (no pull-up)");
    rd(3'd0, 8'h00, "R3 read input pads A");
    wr(3'd1, 8'h00);
    expect_v(1, 32'hFF, 32'hFF, "R1 pull-up latch value");
    expect_v(6, 32'hFF, 32'h00, "R1 latch without pull-up");

    wr(3'd0, 8'h5A);
    expect_v(1, 32'hFF, 32'h5A, "R2 latch write A");
    rd(3'd0, 8'h5A, "R3 read driven pads A");
    rd(3'd1, 8'h00, "R2 read direction A");
    ext[15:8] = 8'hC3;
    rd(3'd2, 8'hC3, "R3 read input pads B");

    wr(3'd3, 8'hF0);
    wr(3'd2, 8'h00);
    ext[15:8] = 8'hA0;
    bop(3'd2, 2'd1, 3'd1);
    expect_v(1, 32'hFF00, 32'hA200, "R4 set picks up input pins");
    ext[15:8] = 8'h50;
    bop(3'd2, 2'd2, 3'd6);
    expect_v(1, 32'hFF00, 32'h1200, "R4 clear");
    bop(3'd2, 2'd3, 3'd3);
    expect_v(1, 32'hFF00, 32'h5A00, "R4 complement");
    ext[15:8] = 8'hF0;
    bop(3'd2, 2'd0, 3'd3);
    expect_v(1, 32'hFF00, 32'h5A00, "R4 kind 0 no change");
    bop(3'd3, 2'd3, 3'd0);
    rd(3'd3, 8'hF1, "R4 complement on direction");
    bop(3'd2, 2'd1, 3'd0);
    expect_v(2, 32'h100, 32'h0, "R8 B0 input with option on");
    expect_v(7, 32'h100, 32'h0, "R8 B0 input with option off");
    bop(3'd3, 2'd3, 3'd0);
    expect_v(6, 32'h100, 32'h100, "R9 B0 drives latch 1");
    expect_v(7, 32'h100, 32'h100, "R9 B0 enabled");
    expect_v(1, 32'h100, 32'h000, "R10 gated with freq low");
    freq_in = 1'b1;
    expect_v(1, 32'h100, 32'h100, "R10 follows freq high");
    bop(3'd2, 2'd2, 3'd0);
    expect_v(1, 32'h100, 32'h000, "R10 latch 0 blocks freq");
    expect_v(6, 32'h100, 32'h000, "R9 B0 drives latch 0");
    freq_in = 1'b0;

    ext[23:16] = 8'hFF;
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h3F, "R5 port C top bits read 0");
    wr(3'd5, 8'h00);
    expect_v(2, 32'hFF_0000, 32'h3F_0000, "R5 port C top bits never drive");
    wr(3'd7, 8'h00);
    wr(3'd6, 8'hFF);
    expect_v(2, 32'hFF00_0000, 32'h0100_0000, "R5 port F drive only bit 0");
    rd(3'd7, 8'h00, "R5 port F direction read");
    rd(3'd6, 8'h01, "R5 port F data read");
    bop(3'd6, 2'd1, 3'd7);
    expect_v(1, 32'hFF00_0000, 32'h0100_0000, "R5 bit op on missing bit");
    expect_v(4, 32'h1, 32'h1, "R11 interrupt follows F0 high");
    expect_v(5, 32'h1, 32'h1, "R11 timer follows C0 high");
    wr(3'd6, 8'h00);
    expect_v(4, 32'h1, 32'h0, "R11 interrupt follows F0 low");
    wr(3'd4, 8'hFE);
    expect_v(5, 32'h1, 32'h0, "R11 timer follows C0 low");

    wr(3'd1, 8'hFF);
    ext[7:0] = 8'h00;
    expect_v(3, 32'h1, 32'h0, "R7 awake idle");
    ext[7:0] = 8'h10;
    expect_v(3, 32'h1, 32'h0, "R7 change while awake");
    sleep_en = 1'b1;
    expect_v(3, 32'h1, 32'h0, "R6 asleep no change");
    ext[7:0] = 8'h18;
    expect_v(3, 32'h1, 32'h1, "R6 change sets wake");
    ext[7:0] = 8'h00;
    expect_v(3, 32'h1, 32'h1, "R6 wake holds");
    sleep_en = 1'b0;
    expect_v(3, 32'h1, 32'h0, "R7 wake clears");

    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule